// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block turns bus addresses that fall inside a fixed aperture window into physical addresses, one 4 KiB page at a time. The window starts at a parameter base address and spans a parameter number of pages. Each page owns one 32-bit table entry. The top bit of an entry marks it as usable, and the bits between bit 30 and bit 12 hold the physical page frame. The table sits in synchronous RAM, and every entry is cleared to zero (unusable) at reset.

Software reaches the table indirectly through three word registers. It first loads a pointer register with the aperture byte address of the page it wants. It then reads or writes the data register, and that access goes to the entry the pointer selects. A third register switches translation on and off. A translation request on the separate lookup port answers one cycle later. The answer is the remapped address, or the unchanged address when the request lies outside the window, or a one-cycle fault.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, the configuration register reads 0 and every table entry reads 0.
- R2: Register word offsets are 0 for configuration (bit 0 is the enable and the other bits read 0), 1 for the entry pointer (all 32 bits are read back) and 2 for entry data. Offset 3 reads 0 and ignores writes. Each read answers in the next cycle with reg_rvalid high.
- R3: A write to offset 2 stores the word in entry (pointer − base) >> 12. Pointer bits 11:0 do not affect the selection.
- R4: A read of offset 2 returns the entry the pointer selects. A read placed in the cycle right after a register write returns the value just written, for the configuration register and for entries alike.
- R5: While the pointer lies outside the window, data writes change no entry and data reads return 0.
- R6: A request inside the window, with translation enabled and an entry whose bit 31 is set, answers in the next cycle with xl_valid high and xl_paddr = {0, entry[30:12], addr[11:0]}.
- R7: A request below the base or above base + pages×4096 − 1 answers with xl_valid high and xl_paddr equal to the request address, whether translation is enabled or not. Both edges of the window are inclusive.
- R8: A request inside the window that hits an entry with bit 31 clear, or that arrives while translation is disabled, raises xl_fault for one cycle with xl_valid low.
- R9: Every request gets exactly one response, in the following cycle. With no request, xl_valid and xl_fault stay low. The enable value in force in the request cycle decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 32 | Bus address to translate |
| xl_valid | output | 1 | Translated or passed-through address valid |
| xl_fault | output | 1 | Translation fault |
| xl_paddr | output | 32 | Resulting physical address |

## Verification
A wrong index calculation, or an entry stored in the wrong slot, shows up one cycle after the next data read or lookup. The wrong frame comes back on reg_rdata or xl_paddr, or a fault appears where a valid answer was expected. An enable flag that is wrong, or a window check that is off by one, flips the valid/fault choice for lookups near the window edges and shows on the very next response. A stale read path breaks the read that directly follows a write, because that read must already see the new value.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam logic [WORD_W-1:0] FRAME_MASK  = 32'h7FFF_F000;
    localparam logic [WORD_W-1:0] OFFSET_MASK = 32'h0000_0FFF;
    localparam int unsigned VALID_BIT  = 31;

    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_PTR   = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] ptr;
        logic              rvalid;
        logic              from_ram;
        logic [WORD_W-1:0] rdata;
    } reg_state_t;

    typedef struct packed {
        logic              req;
        logic              in_win;
        logic              en;
        logic [WORD_W-1:0] addr;
    } xl_stage_t;

endpackage

// File: rtl/remap_table_ram.sv
module remap_table_ram #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] a_addr,
    output logic [DW-1:0]    a_data,
    input  logic [IDX_W-1:0] b_addr,
    output logic [DW-1:0]    b_data
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] a_q, b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (we) mem_q[waddr] <= wdata;
            a_q <= mem_q[a_addr];
            b_q <= mem_q[b_addr];
        end
    end

    assign a_data = a_q;
    assign b_data = b_q;
endmodule

// File: rtl/remap_regs.sv
module remap_regs
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'h0010_0000,
    parameter int unsigned PAGE_COUNT = 16,
    parameter int unsigned IDX_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              en_o,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_idx,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic [WORD_W-1:0] ram_rdata
);
    localparam logic [WORD_W-1:0] APER_LAST =
        APER_BASE + WORD_W'(PAGE_COUNT) * (WORD_W'(1) << PAGE_SHIFT) - WORD_W'(1);

    reg_state_t st_d, st_q;
    logic       ptr_in_win;
    reg_sel_e   sel;

    assign sel        = reg_sel_e'(reg_addr);
    assign ptr_in_win = (st_q.ptr >= APER_BASE) && (st_q.ptr <= APER_LAST);
    assign ram_idx    = IDX_W'((st_q.ptr - APER_BASE) >> PAGE_SHIFT);
    assign ram_we     = reg_wr && (sel == SEL_DATA) && ptr_in_win;
    assign ram_wdata  = reg_wdata;

    always_comb begin
        st_d          = st_q;
        st_d.rvalid   = reg_rd;
        st_d.from_ram = 1'b0;
        st_d.rdata    = '0;
        if (reg_wr) begin
            case (sel)
                SEL_CFG: st_d.en  = reg_wdata[0];
                SEL_PTR: st_d.ptr = reg_wdata;
                default: ;
            endcase
        end
        if (reg_rd) begin
            case (sel)
                SEL_CFG:  st_d.rdata    = {{(WORD_W-1){1'b0}}, st_q.en};
                SEL_PTR:  st_d.rdata    = st_q.ptr;
                SEL_DATA: st_d.from_ram = ptr_in_win;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata  = st_q.from_ram ? ram_rdata : st_q.rdata;
    assign reg_rvalid = st_q.rvalid;
    assign en_o       = st_q.en;

    p_read_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    p_cfg_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> (en_o == $past(reg_wdata[0])));
    p_outside_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && ((st_q.ptr < APER_BASE) || (st_q.ptr > APER_LAST)))
        |-> !ram_we);
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'h0010_0000,
    parameter int unsigned PAGE_COUNT = 16,
    parameter int unsigned IDX_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              xl_req,
    input  logic [WORD_W-1:0] xl_addr,
    output logic [IDX_W-1:0]  ram_idx,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              xl_valid,
    output logic              xl_fault,
    output logic [WORD_W-1:0] xl_paddr
);
    localparam logic [WORD_W-1:0] APER_LAST =
        APER_BASE + WORD_W'(PAGE_COUNT) * (WORD_W'(1) << PAGE_SHIFT) - WORD_W'(1);

    xl_stage_t stg_d, stg_q;

    assign ram_idx = IDX_W'((xl_addr - APER_BASE) >> PAGE_SHIFT);

    always_comb begin
        stg_d.req    = xl_req;
        stg_d.in_win = (xl_addr >= APER_BASE) && (xl_addr <= APER_LAST);
        stg_d.en     = en_i;
        stg_d.addr   = xl_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    always_comb begin
        xl_valid = 1'b0;
        xl_fault = 1'b0;
        xl_paddr = '0;
        if (stg_q.req) begin
            if (!stg_q.in_win) begin
                xl_valid = 1'b1;
                xl_paddr = stg_q.addr;
            end else if (stg_q.en && ram_rdata[VALID_BIT]) begin
                xl_valid = 1'b1;
                xl_paddr = (ram_rdata & FRAME_MASK) | (stg_q.addr & OFFSET_MASK);
            end else begin
                xl_fault = 1'b1;
            end
        end
    end

    p_one_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> (xl_valid != xl_fault));
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |=> !(xl_valid || xl_fault));
    p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> (!xl_valid || (xl_paddr[11:0] == $past(xl_addr[11:0]))));
    p_disabled_no_remap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !en_i) |=> (!xl_valid || (xl_paddr == $past(xl_addr))));
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'h0010_0000,
    parameter int unsigned PAGE_COUNT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid,
    input  logic        xl_req,
    input  logic [31:0] xl_addr,
    output logic        xl_valid,
    output logic        xl_fault,
    output logic [31:0] xl_paddr
);
    localparam int unsigned IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

    logic              en;
    logic              ram_we;
    logic [IDX_W-1:0]  reg_idx, xl_idx;
    logic [WORD_W-1:0] ram_wdata, reg_entry, xl_entry;

    remap_regs #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .en_o(en), .ram_we(ram_we), .ram_idx(reg_idx),
        .ram_wdata(ram_wdata), .ram_rdata(reg_entry)
    );

    remap_table_ram #(.DEPTH(PAGE_COUNT), .IDX_W(IDX_W), .DW(WORD_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(reg_idx), .wdata(ram_wdata),
        .a_addr(reg_idx), .a_data(reg_entry), .b_addr(xl_idx), .b_data(xl_entry)
    );

    remap_xlate #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_xlate (
        .clk(clk), .rst_n(rst_n), .en_i(en), .xl_req(xl_req), .xl_addr(xl_addr),
        .ram_idx(xl_idx), .ram_rdata(xl_entry), .xl_valid(xl_valid),
        .xl_fault(xl_fault), .xl_paddr(xl_paddr)
    );
endmodule

// File: tb/aperture_remap_test.sv
`timescale 1ns/1ps
module aperture_remap_test;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        xl_req = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        xl_valid, xl_fault;
    logic [31:0] xl_paddr;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    aperture_remap #(.APER_BASE(BASE), .PAGE_COUNT(16)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .xl_req(xl_req), .xl_addr(xl_addr),
        .xl_valid(xl_valid), .xl_fault(xl_fault), .xl_paddr(xl_paddr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = off;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R2 rvalid", {31'b0, reg_rvalid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic xl(input logic [31:0] a, output logic v, output logic f, output logic [31:0] p);
        @(negedge clk);
        xl_req = 1'b1; xl_addr = a;
        @(negedge clk);
        xl_req = 1'b0;
        v = xl_valid; f = xl_fault; p = xl_paddr;
    endtask

    task automatic t_reset_state();
        logic [31:0] d; logic v, f; logic [31:0] p;
        rd(2'd0, d);  check("R1 cfg after reset", d, 32'd0);
        wr(2'd1, BASE + 32'h3000);
        rd(2'd2, d);  check("R1 entry after reset", d, 32'd0);
        xl(BASE + 32'h3010, v, f, p);
        check("R1 fault while disabled", {30'b0, v, f}, 32'd1);
    endtask

    task automatic t_reg_access();
        logic [31:0] d;
        wr(2'd1, BASE + 32'h1234);
        rd(2'd1, d);  check("R2 pointer readback", d, BASE + 32'h1234);
        wr(2'd2, 32'h8004_5000);
        rd(2'd2, d);  check("R4 data read right after write", d, 32'h8004_5000);
        wr(2'd1, BASE + 32'h1FFF);
        rd(2'd2, d);  check("R3 low pointer bits ignored", d, 32'h8004_5000);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d);  check("R2 spare offset reads zero", d, 32'd0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d);  check("R4 cfg read right after write", d, 32'd1);
    endtask

    task automatic t_translate();
        logic v, f; logic [31:0] p;
        xl(BASE + 32'h1ABC, v, f, p);
        check("R6 valid flag", {31'b0, v}, 32'd1);
        check("R6 remapped address", p, 32'h0004_5ABC);
        wr(2'd1, BASE + 32'hF000);
        wr(2'd2, 32'h8FFF_F000);
        xl(BASE + 32'hFFFF, v, f, p);
        check("R6 last page top byte", p, 32'h0FFF_FFFF);
        check("R7 last window byte is remapped", {30'b0, v, f}, 32'd2);
        xl(BASE + 32'h2000, v, f, p);
        check("R8 fault on invalid entry", {30'b0, v, f}, 32'd1);
        @(negedge clk);
        check("R9 quiet without request", {30'b0, xl_valid, xl_fault}, 32'd0);
    endtask

    task automatic t_outside();
        logic v, f; logic [31:0] p;
        xl(BASE - 32'd4, v, f, p);
        check("R7 below base passes", {30'b0, v, f}, 32'd2);
        check("R7 below base address", p, BASE - 32'd4);
        xl(BASE + 32'h0001_0000, v, f, p);
        check("R7 past end passes", p, BASE + 32'h0001_0000);
        wr(2'd0, 32'd0);
        xl(32'h0000_0040, v, f, p);
        check("R7 passes while disabled", {v, f, p[29:0]}, {2'b10, 30'h40});
        xl(BASE + 32'h1ABC, v, f, p);
        check("R8 fault when disabled", {30'b0, v, f}, 32'd1);
    endtask

    task automatic t_ptr_outside();
        logic [31:0] d;
        wr(2'd1, 32'h0020_0000);
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, d);  check("R5 outside pointer reads zero", d, 32'd0);
        wr(2'd1, BASE);
        rd(2'd2, d);  check("R5 entry 0 untouched", d, 32'd0);
    endtask

    task automatic t_enable_timing();
        logic v, f; logic [31:0] p;
        @(negedge clk);
        xl_req = 1'b1; xl_addr = BASE + 32'h1004;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
        @(negedge clk);
        xl_req = 1'b0; reg_wr = 1'b0;
        check("R9 enable taken at request", {30'b0, xl_valid, xl_fault}, 32'd1);
        xl(BASE + 32'h1004, v, f, p);
        check("R9 next request sees enable", p, 32'h0004_5004);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_reg_access();
        t_translate();
        t_outside();
        t_ptr_outside();
        t_enable_timing();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule